// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss in hardware. When it receives a 20-bit virtual page number and an access type, it walks a two-level tree of page tables in memory. The walk starts at a root pointer held in an internal register. The upper ten bits of the page number select a word in the first-level table, and that word points to a second-level table. The lower ten bits then select the page table entry inside that second-level table. Every table holds 1024 words of four bytes, so each one fills a single 4 KB page.

The walker reads memory through a single request/response port. It issues the two reads one after the other and never has more than one outstanding. It ends each walk with a one-cycle `done` pulse that carries exactly one of four outcomes:

- success, with the physical page number;
- missing second-level table (zero pointer);
- page not present (invalid entry);
- protection violation.

Software loads the root pointer through a write strobe while the walker is idle. The caller waits for `busy` to be low before it starts a new walk.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `memReqValid` and `done` are low and the root register is zero.
- R2: The first read goes to root + 4*vpn[19:10]. The request address stays stable while `memReqValid` is high and `memReqReady` is low.
- R3: A first-level word equal to zero ends the walk with result code 1 (no table). In that case no second read is issued.
- R4: The second read goes to pointer + 4*vpn[9:0], where the pointer is the full 32-bit first-level word.
- R5: The entry layout is: bit 0 valid, bit 1 dirty, bit 2 read allowed, bit 3 write allowed, bit 4 execute allowed, bits [31:12] physical page number. An entry with bit 0 clear gives result code 2 (not present).
- R6: The access type is 0 read, 1 write, 2 execute, 3 reserved. If the matching permission bit is clear, or the type is 3, the result code is 3 (protection).
- R7: On success the result code is 0 and `resultPpn` equals entry bits [31:12]. The dirty bit does not affect the result. On any fault `resultPpn` is zero.
- R8: `startValid` and `rootWe` are ignored while `busy` is high. Such a pulse neither alters the walk in progress nor starts another walk.
- R9: `done` is high for exactly one cycle per accepted walk. `busy` is high from the cycle after the start is accepted through the `done` cycle, and is low in the cycle after `done`.
- R10: An invalid entry reports code 2 even when its permission bits would also deny the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWe | input | 1 | Load the root register (accepted only when idle) |
| rootData | input | 32 | New root pointer value |
| startValid | input | 1 | Start a walk (accepted only when idle) |
| startVpn | input | 20 | Virtual page number to translate |
| startAcc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | A walk is in progress |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Byte address of the word to read |
| memRspValid | input | 1 | Read data is valid |
| memRspData | input | 32 | Read data word |
| done | output | 1 | One-cycle pulse marking the end of a walk |
| resultCode | output | 2 | 0 success, 1 no table, 2 not present, 3 protection |
| resultPpn | output | 20 | Physical page number on success, zero otherwise |

## Verification
The hardest case to reach is a start or root write that arrives in the middle of a walk while the memory is stalling the request. The bench holds `memReqReady` low for several cycles and, during that stall, pulses `startValid` and `rootWe` with different values. It checks that the held address never moves. It then checks that no extra walk follows the `done` pulse, and that the next walk still uses the old root.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PPN_W      = WORD_W - PAGE_SHIFT;

  // entry bit positions
  localparam int PTE_VALID = 0;
  localparam int PTE_DIRTY = 1;
  localparam int PTE_RD    = 2;
  localparam int PTE_WR    = 3;
  localparam int PTE_EX    = 4;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_NO_TABLE = 2'd1,
    RES_ABSENT   = 2'd2,
    RES_PROT     = 2'd3
  } walkRes_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSV   = 2'd3
  } walkAcc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capStart;
    logic capPtr;
    logic capNull;
    logic capPte;
    logic selL2;
  } walkCtl_t;

  // validity first, then permission
  function automatic walkRes_e classifyPte(input logic [4:0] flags, input walkAcc_e acc);
    walkRes_e res;
    if (!flags[PTE_VALID]) begin
      res = RES_ABSENT;
    end else begin
      unique case (acc)
        ACC_READ:  res = flags[PTE_RD] ? RES_OK : RES_PROT;
        ACC_WRITE: res = flags[PTE_WR] ? RES_OK : RES_PROT;
        ACC_EXEC:  res = flags[PTE_EX] ? RES_OK : RES_PROT;
        default:   res = RES_PROT;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startValid,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     ptrNull,
  output walkCtl_t ctl,
  output logic     busy,
  output logic     memReqValid,
  output logic     done
);

  walkState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          ctl.capStart = 1'b1;
          stateNxt     = ST_L1_REQ;
        end
      end
      ST_L1_REQ: begin
        if (memReqReady) stateNxt = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (memRspValid) begin
          if (ptrNull) begin
            ctl.capNull = 1'b1;
            stateNxt    = ST_DONE;
          end else begin
            ctl.capPtr = 1'b1;
            stateNxt   = ST_L2_REQ;
          end
        end
      end
      ST_L2_REQ: begin
        ctl.selL2 = 1'b1;
        if (memReqReady) stateNxt = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        ctl.selL2 = 1'b1;
        if (memRspValid) begin
          ctl.capPte = 1'b1;
          stateNxt   = ST_DONE;
        end
      end
      ST_DONE:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign done        = (state == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !done)); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> (busy && memReqValid)); // R9
  AST_NULL_NO_L2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capNull |=> (done && !memReqValid)); // R3

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int L1_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic              busy,
  input  logic              rootWe,
  input  logic [WORD_W-1:0] rootData,
  input  logic [VPN_W-1:0]  startVpn,
  input  logic [1:0]        startAcc,
  input  logic [WORD_W-1:0] memRspData,
  output logic              ptrNull,
  output logic [WORD_W-1:0] memReqAddr,
  output logic [1:0]        resultCode,
  output logic [PPN_W-1:0]  resultPpn
);

  localparam int L2_IDX_W = VPN_W - L1_IDX_W;
  localparam int PAD1_W   = WORD_W - L1_IDX_W - 2;
  localparam int PAD2_W   = WORD_W - L2_IDX_W - 2;

  logic [WORD_W-1:0] rootQ;
  logic [WORD_W-1:0] ptrQ;
  logic [VPN_W-1:0]  vpnQ;
  walkAcc_e          accQ;
  walkRes_e          codeQ;
  logic [PPN_W-1:0]  ppnQ;

  logic [L1_IDX_W-1:0] idx1;
  logic [L2_IDX_W-1:0] idx2;
  logic [WORD_W-1:0]   off1, off2, addr1, addr2;
  walkRes_e            pteRes;

  always_ff @(posedge clk) begin
    if (!rstN)               rootQ <= '0;
    else if (rootWe && !busy) rootQ <= rootData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ <= '0;
      accQ <= ACC_READ;
    end else if (ctl.capStart) begin
      vpnQ <= startVpn;
      accQ <= walkAcc_e'(startAcc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ptrQ <= '0;
    else if (ctl.capPtr) ptrQ <= memRspData;
  end

  assign idx1  = vpnQ[VPN_W-1:L2_IDX_W];
  assign idx2  = vpnQ[L2_IDX_W-1:0];
  assign off1  = {{PAD1_W{1'b0}}, idx1, 2'b00};
  assign off2  = {{PAD2_W{1'b0}}, idx2, 2'b00};
  assign addr1 = rootQ + off1;
  assign addr2 = ptrQ + off2;
  assign memReqAddr = ctl.selL2 ? addr2 : addr1;

  assign ptrNull = (memRspData == '0);
  assign pteRes  = classifyPte(memRspData[PTE_EX:PTE_VALID], accQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= RES_OK;
      ppnQ  <= '0;
    end else if (ctl.capNull) begin
      codeQ <= RES_NO_TABLE;
      ppnQ  <= '0;
    end else if (ctl.capPte) begin
      codeQ <= pteRes;
      ppnQ  <= (pteRes == RES_OK) ? memRspData[WORD_W-1:PAGE_SHIFT] : '0;
    end
  end

  assign resultCode = codeQ;
  assign resultPpn  = ppnQ;

  AST_ROOT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(rootQ)); // R8
  AST_VPN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.capStart) |=> $stable(vpnQ)); // R8
  AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capPte && !memRspData[PTE_VALID]) |=> (resultCode == 2'd2)); // R10

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int L1_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rootWe,
  input  logic [WORD_W-1:0] rootData,
  input  logic              startValid,
  input  logic [VPN_W-1:0]  startVpn,
  input  logic [1:0]        startAcc,
  output logic              busy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [WORD_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic              done,
  output logic [1:0]        resultCode,
  output logic [PPN_W-1:0]  resultPpn
);

  walkCtl_t ctl;
  logic     ptrNull;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .ptrNull     (ptrNull),
    .ctl         (ctl),
    .busy        (busy),
    .memReqValid (memReqValid),
    .done        (done)
  );

  pt_walker_dp #(
    .VPN_W    (VPN_W),
    .L1_IDX_W (L1_IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busy       (busy),
    .rootWe     (rootWe),
    .rootData   (rootData),
    .startVpn   (startVpn),
    .startAcc   (startAcc),
    .memRspData (memRspData),
    .ptrNull    (ptrNull),
    .memReqAddr (memReqAddr),
    .resultCode (resultCode),
    .resultPpn  (resultPpn)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R2
  AST_FAULT_ZERO_PPN: assert property (@(posedge clk) disable iff (!rstN)
    (done && resultCode != 2'd0) |-> (resultPpn == '0)); // R7

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rootWe;
  logic [31:0] rootData;
  logic        startValid;
  logic [19:0] startVpn;
  logic [1:0]  startAcc;
  logic        busy, memReqValid, memReqReady, memRspValid, done;
  logic [31:0] memReqAddr, memRspData;
  logic [1:0]  resultCode;
  logic [19:0] resultPpn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN), .rootWe(rootWe), .rootData(rootData),
    .startValid(startValid), .startVpn(startVpn), .startAcc(startAcc),
    .busy(busy), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .resultCode(resultCode), .resultPpn(resultPpn)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expCode(input logic [31:0] w, input logic [1:0] acc);
    if (!w[0]) return 2'd2;
    case (acc)
      2'd0: return w[2] ? 2'd0 : 2'd3;
      2'd1: return w[3] ? 2'd0 : 2'd3;
      2'd2: return w[4] ? 2'd0 : 2'd3;
      default: return 2'd3;
    endcase
  endfunction

  task automatic setRoot(input logic [31:0] r);
    @(negedge clk); rootWe = 1'b1; rootData = r;
    @(negedge clk); rootWe = 1'b0;
  endtask

  // runs one walk, serving reads with w1 then w2
  task automatic runWalk(input logic [19:0] vpn, input logic [1:0] acc,
                         input logic [31:0] w1, input logic [31:0] w2,
                         input int stall, input bit poke,
                         output logic [1:0] code, output logic [19:0] ppn,
                         output logic [31:0] a1, output logic [31:0] a2,
                         output int nReq);
    bit seenDone = 0;
    bit pendRsp = 0;
    int waitCnt = 0;
    logic [31:0] held = '0;
    nReq = 0; a1 = '0; a2 = '0; code = 'x; ppn = 'x;
    @(negedge clk); startValid = 1'b1; startVpn = vpn; startAcc = acc;
    @(negedge clk);
    for (int it = 0; it < 80 && !seenDone; it++) begin
      startValid = 1'b0; rootWe = 1'b0;
      memRspValid = 1'b0; memReqReady = 1'b0;
      if (poke && it == 1) begin
        startValid = 1'b1; startVpn = ~vpn; rootWe = 1'b1; rootData = 32'h7777_0000;
      end
      if (done) begin
        seenDone = 1; code = resultCode; ppn = resultPpn;
      end else if (pendRsp) begin
        memRspValid = 1'b1;
        memRspData = (nReq == 1) ? w1 : w2;
        pendRsp = 0;
      end else if (memReqValid) begin
        if (waitCnt == 0) held = memReqAddr;
        else check("R2 held address", memReqAddr, held);
        if (waitCnt < stall) begin
          waitCnt++;
        end else begin
          memReqReady = 1'b1;
          if (nReq == 0) a1 = memReqAddr; else a2 = memReqAddr;
          nReq++; waitCnt = 0; pendRsp = 1;
        end
      end
      if (!seenDone) @(negedge clk);
    end
    check("R9 done seen", {31'd0, seenDone}, 32'd1);
    @(negedge clk);
    check("R9 done single cycle", {31'd0, done}, 32'd0);
    check("R9 busy low after done", {31'd0, busy}, 32'd0);
    check("R8 no extra walk", {31'd0, memReqValid}, 32'd0);
  endtask

  task automatic fullWalk(input string tag, input logic [31:0] root,
                          input logic [19:0] vpn, input logic [1:0] acc,
                          input logic [31:0] w1, input logic [31:0] w2,
                          input int stall, input bit poke);
    logic [1:0] code; logic [19:0] ppn; logic [31:0] a1, a2; int n;
    logic [1:0] ec;
    runWalk(vpn, acc, w1, w2, stall, poke, code, ppn, a1, a2, n);
    check({tag, " R2 level1 address"}, a1, root + {20'd0, vpn[19:10], 2'b00});
    if (w1 == 0) begin
      check({tag, " R3 no-table code"}, {30'd0, code}, 32'd1);
      check({tag, " R3 single read"}, n, 32'd1);
      check({tag, " R7 fault ppn zero"}, {12'd0, ppn}, 32'd0);
    end else begin
      ec = expCode(w2, acc);
      check({tag, " R4 level2 address"}, a2, w1 + {20'd0, vpn[9:0], 2'b00});
      check({tag, " R4 two reads"}, n, 32'd2);
      check({tag, " R5 R6 R10 code"}, {30'd0, code}, {30'd0, ec});
      check({tag, " R7 ppn"}, {12'd0, ppn}, (ec == 2'd0) ? {12'd0, w2[31:12]} : 32'd0);
    end
  endtask

  task automatic testReset();
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 memReqValid", {31'd0, memReqValid}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; rootWe = 1'b0; rootData = '0; startValid = 1'b0;
    startVpn = '0; startAcc = '0; memReqReady = 1'b0; memRspValid = 1'b0;
    memRspData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // R1 root zero: first address is 4*idx
    fullWalk("root zero", 32'h0, 20'h00400, 2'd0, 32'h0000_5000, 32'hABCDE005, 0, 0);

    setRoot(32'h0001_0000);
    fullWalk("read ok", 32'h0001_0000, 20'h12345, 2'd0, 32'h0020_0000, 32'hABCDE005, 0, 0);
    fullWalk("null ptr", 32'h0001_0000, 20'h3FF01, 2'd0, 32'h0, 32'h0, 1, 0);
    fullWalk("invalid R10", 32'h0001_0000, 20'h00001, 2'd1, 32'h0030_0000, 32'h1234501C, 0, 0);
    fullWalk("invalid noperm", 32'h0001_0000, 20'h00002, 2'd2, 32'h0030_0000, 32'h12345002, 0, 0);
    fullWalk("write denied R6", 32'h0001_0000, 20'h55555, 2'd1, 32'h0040_0000, 32'h11111015, 0, 0);
    fullWalk("write ok", 32'h0001_0000, 20'h55555, 2'd1, 32'h0040_0000, 32'h2222200D, 0, 0);
    fullWalk("exec dirty R7", 32'h0001_0000, 20'hAAAAA, 2'd2, 32'h0050_0000, 32'hFEDCB013, 0, 0);
    fullWalk("exec denied", 32'h0001_0000, 20'hAAAAA, 2'd2, 32'h0050_0000, 32'hFEDCB00F, 0, 0);
    fullWalk("reserved acc R6", 32'h0001_0000, 20'h0F0F0, 2'd3, 32'h0060_0000, 32'h3333301D, 0, 0);
    fullWalk("max vpn", 32'h0001_0000, 20'hFFFFF, 2'd0, 32'h0070_0000, 32'h44444005, 0, 0);
    fullWalk("min vpn", 32'h0001_0000, 20'h00000, 2'd0, 32'h0080_0000, 32'h55555005, 0, 0);
    // R8: stall the port and poke start/root mid-walk
    fullWalk("stall poke R8", 32'h0001_0000, 20'h2468A, 2'd0, 32'h0090_0000, 32'h66666005, 3, 1);
    fullWalk("root kept R8", 32'h0001_0000, 20'h13579, 2'd0, 32'h00A0_0000, 32'h77777005, 2, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule